// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers a vector of interrupt request lines into a single request for a parent interrupt controller. Each source is first brought into the local clock domain. It is then judged by its own sensing rule, which is either a level or an edge, with the active sense chosen per source. A qualifying event latches a pending bit. Software acknowledges a pending bit by writing one to it, can inject pending bits from a force register, and gates each source onto the output with an enable mask.

The combined request is the OR of pending AND enable. It drives the output line either as a level or as a one-cycle pulse, with selectable polarity. Software reaches the block over a plain register port: a byte address, write data, a write strobe, a read strobe and combinational read data. At start-up, software clears the enable mask and the output settings and acknowledges every status bit. After changing the mode or sense of a source, software acknowledges that source so that any event caused by the change is discarded.

Top module: `irqagg_top`

## Requirements
- R1: Asynchronous active-low reset clears every register. While reset is held, every offset reads zero and `irqOut` is high, because the output defaults to an active-low level with nothing enabled.
- R2: Each source passes through two synchronising flip-flops. A change on `srcIn` that is set up before a rising edge can first appear in the pending status after the third rising edge, and not after the second.
- R3: With the source-mode bit at 1 (edge sensing), a source-sense bit of 1 latches pending on a 0-to-1 transition and a sense bit of 0 latches it on a 1-to-0 transition. The opposite transition latches nothing.
- R4: With the source-mode bit at 0 (level sensing), the pending bit is set on every cycle in which the synchronised input is at its active level: high for sense 1, low for sense 0. An acknowledge therefore has no lasting effect while the input stays active.
- R5: Writing the status register (offset 0x04) clears each pending bit written with 1 and leaves bits written with 0 unchanged. A set and a clear of the same bit in the same cycle leave it set.
- R6: Writing 1 to a bit of the force register (offset 0x18) sets that pending bit at the same clock edge. The force register always reads zero.
- R7: A zero bit in the enable register (offset 0x00) keeps that pending bit away from the output. Masking never clears the pending bit.
- R8: With output mode (offset 0x10, bit 0) at 0, `irqOut` sits at its active level whenever any enabled pending bit is set. Output sense (offset 0x14, bit 0) at 1 means active high; at 0 it means active low.
- R9: With output mode at 1, `irqOut` shows a single-cycle pulse at the active level in the cycle after the masked request goes from zero to nonzero. It is at the inactive level otherwise.
- R10: The source mode and source sense registers are at offsets 0x08 and 0x0C. Read data is valid while `busRdEn` is high and zero otherwise. The mode and sense registers read back as written. Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC (32) | Interrupt request inputs, asynchronous |
| busAddr | input | ADDR_W (5) | Register byte address |
| busWrData | input | NUM_SRC (32) | Register write data |
| busWrEn | input | 1 | Write strobe, one write per clock |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | NUM_SRC (32) | Read data, combinational, zero when not reading |
| irqOut | output | 1 | Aggregated request to the parent controller |

## Verification
The bench sweeps all four combinations of source mode and sense across every source at once. In each combination it drives a multi-bit toggle pattern away from the idle level and then back. This separates the wanted transition from the opposite one, and it separates sticky latching from level re-assertion. The pending status is sampled one cycle before and exactly at the expected latency, which fixes the synchronizer depth. A half-word acknowledge and a full acknowledge taken while inputs are still active tell apart write-one-to-clear, write-zero-has-no-effect and set-over-clear. Force bits are combined with enable masks that are either disjoint from or overlapping the pending set, and each output mode and sense is checked on the request's rising step and on the cycle after it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam logic [7:0] OFS_ENABLE  = 8'h00;
  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_SRCMODE = 8'h08;
  localparam logic [7:0] OFS_SRCPOL  = 8'h0C;
  localparam logic [7:0] OFS_OUTMODE = 8'h10;
  localparam logic [7:0] OFS_OUTPOL  = 8'h14;
  localparam logic [7:0] OFS_FORCE   = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS,
    SEL_SRCMODE,
    SEL_SRCPOL,
    SEL_OUTMODE,
    SEL_OUTPOL
  } readSel_e;

  typedef struct packed {
    logic     wrEnable;
    logic     wrStatus;
    logic     wrSrcMode;
    logic     wrSrcPol;
    logic     wrOutMode;
    logic     wrOutPol;
    logic     wrForce;
    readSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobes_t       strobes
);

  readSel_e hitSel;

  always_comb begin
    strobes = '0;
    hitSel  = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFS_ENABLE):  begin strobes.wrEnable  = busWrEn; hitSel = SEL_ENABLE;  end
      ADDR_W'(OFS_STATUS):  begin strobes.wrStatus  = busWrEn; hitSel = SEL_STATUS;  end
      ADDR_W'(OFS_SRCMODE): begin strobes.wrSrcMode = busWrEn; hitSel = SEL_SRCMODE; end
      ADDR_W'(OFS_SRCPOL):  begin strobes.wrSrcPol  = busWrEn; hitSel = SEL_SRCPOL;  end
      ADDR_W'(OFS_OUTMODE): begin strobes.wrOutMode = busWrEn; hitSel = SEL_OUTMODE; end
      ADDR_W'(OFS_OUTPOL):  begin strobes.wrOutPol  = busWrEn; hitSel = SEL_OUTPOL;  end
      ADDR_W'(OFS_FORCE):   strobes.wrForce = busWrEn;
      default: ;
    endcase
    strobes.rdSel = busRdEn ? hitSel : SEL_NONE;
  end

endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               maskedAny,
  output logic               outModeQ,
  output logic               outPolQ
);

  logic [NUM_SRC-1:0] syncA, syncB, prevB;
  logic [NUM_SRC-1:0] enableQ, pendQ, modeQ, polQ;
  logic [NUM_SRC-1:0] srcEvent, forceSet, ackClr;

  // per-source sensing slice
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sense
    logic lvlHit, edgeHit;
    assign lvlHit      = polQ[i] ? syncB[i] : ~syncB[i];
    assign edgeHit     = polQ[i] ? (syncB[i] & ~prevB[i]) : (~syncB[i] & prevB[i]);
    assign srcEvent[i] = modeQ[i] ? edgeHit : lvlHit;
  end

  assign forceSet = strobes.wrForce  ? wrData : '0;
  assign ackClr   = strobes.wrStatus ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
      pendQ <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      prevB <= syncB;
      pendQ <= (pendQ & ~ackClr) | srcEvent | forceSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= '0;
      modeQ    <= '0;
      polQ     <= '0;
      outModeQ <= 1'b0;
      outPolQ  <= 1'b0;
    end else begin
      if (strobes.wrEnable)  enableQ  <= wrData;
      if (strobes.wrSrcMode) modeQ    <= wrData;
      if (strobes.wrSrcPol)  polQ     <= wrData;
      if (strobes.wrOutMode) outModeQ <= wrData[0];
      if (strobes.wrOutPol)  outPolQ  <= wrData[0];
    end
  end

  assign maskedAny = |(pendQ & enableQ);

  always_comb begin
    case (strobes.rdSel)
      SEL_ENABLE:  rdData = enableQ;
      SEL_STATUS:  rdData = pendQ;
      SEL_SRCMODE: rdData = modeQ;
      SEL_SRCPOL:  rdData = polQ;
      SEL_OUTMODE: rdData = NUM_SRC'(outModeQ);
      SEL_OUTPOL:  rdData = NUM_SRC'(outPolQ);
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/irqagg_outgen.sv
module irqagg_outgen (
  input  logic clk,
  input  logic rstN,
  input  logic maskedAny,
  input  logic outMode,
  input  logic outPol,
  output logic irqOut
);

  logic anyPrev;
  logic activeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyPrev <= 1'b0;
    else       anyPrev <= maskedAny;
  end

  assign activeNow = outMode ? (maskedAny & ~anyPrev) : maskedAny;
  assign irqOut    = outPol ? activeNow : ~activeNow;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWrData,
  input  logic               busWrEn,
  input  logic               busRdEn,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqOut
);

  regStrobes_t strobes;
  logic        maskedAny;
  logic        outModeQ;
  logic        outPolQ;

  irqagg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  irqagg_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strobes   (strobes),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .maskedAny (maskedAny),
    .outModeQ  (outModeQ),
    .outPolQ   (outPolQ)
  );

  irqagg_outgen u_out (
    .clk       (clk),
    .rstN      (rstN),
    .maskedAny (maskedAny),
    .outMode   (outModeQ),
    .outPol    (outPolQ),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busRdEn,
  input logic [NUM_SRC-1:0] busRdData,
  input logic               maskedAny,
  input logic               outModeQ,
  input logic               outPolQ,
  input logic               irqOut
);

  logic readsBack;
  assign readsBack = (busAddr == ADDR_W'(OFS_ENABLE))  || (busAddr == ADDR_W'(OFS_STATUS)) ||
                     (busAddr == ADDR_W'(OFS_SRCMODE)) || (busAddr == ADDR_W'(OFS_SRCPOL)) ||
                     (busAddr == ADDR_W'(OFS_OUTMODE)) || (busAddr == ADDR_W'(OFS_OUTPOL));

  a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !readsBack |-> busRdData == '0);

  a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == '0);

  a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == ADDR_W'(OFS_FORCE) |-> busRdData == '0);

  a_r8_level_active: assert property (@(posedge clk) disable iff (!rstN)
    !outModeQ && maskedAny |-> irqOut == outPolQ);

  a_r8_level_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outModeQ && !maskedAny |-> irqOut == !outPolQ);

  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    outModeQ && $rose(maskedAny) |-> irqOut == outPolQ);

  a_r9_no_pulse_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    outModeQ && !$rose(maskedAny) |-> irqOut == !outPolQ);

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (outModeQ && irqOut == outPolQ) ##1 (outModeQ && $stable(outPolQ)) |-> irqOut != outPolQ);

endmodule

bind irqagg_top irqagg_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .maskedAny (maskedAny),
  .outModeQ  (outModeQ),
  .outPolQ   (outPolQ),
  .irqOut    (irqOut)
);

// File: tb/irqagg_top_test.sv
`timescale 1ns/1ps
module irqagg_top_test;

  localparam logic [4:0] A_EN = 5'h00, A_ST = 5'h04, A_MD = 5'h08, A_PL = 5'h0C;
  localparam logic [4:0] A_OM = 5'h10, A_OP = 5'h14, A_FC = 5'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '1;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  irqagg_top uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] v);
    busAddr = a; busRdEn = 1'b1;
    #1;
    v = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state, read while reset is held
    expectReg("R1 enable", A_EN, 32'h0);
    expectReg("R1 status", A_ST, 32'h0);
    expectReg("R1 srcmode", A_MD, 32'h0);
    expectReg("R1 srcpol", A_PL, 32'h0);
    expectReg("R1 outmode", A_OM, 32'h0);
    expectReg("R1 outpol", A_OP, 32'h0);
    expectReg("R1 force", A_FC, 32'h0);
    check("R1 irqOut", {31'h0, irqOut}, 32'h1);
    rstN = 1'b1;
    tick(2);

    for (int c = 0; c < 4; c++) begin
      logic [31:0] md, pl, idle, pat;
      md   = c[1] ? 32'hFFFF_FFFF : 32'h0;
      pl   = c[0] ? 32'hFFFF_FFFF : 32'h0;
      idle = ~pl;
      pat  = 32'h9A3C_61E5 ^ (32'h0101_0101 << c);
      srcIn = idle;
      wrReg(A_MD, md);
      wrReg(A_PL, pl);
      expectReg("R10 srcmode readback", A_MD, md);
      tick(4);
      wrReg(A_ST, 32'hFFFF_FFFF);
      expectReg("R5 full ack", A_ST, 32'h0);
      // R2: latency through the two-stage synchronizer
      srcIn = idle ^ pat;
      tick(2);
      expectReg("R2 not before third edge", A_ST, 32'h0);
      tick(1);
      expectReg(md[0] ? "R3 active edge" : "R4 active level", A_ST, pat);
      // R3: reverse transition latches nothing; bits stay sticky
      srcIn = idle;
      tick(4);
      expectReg("R3 reverse transition", A_ST, pat);
      wrReg(A_ST, 32'h0000_FFFF);
      expectReg("R5 partial ack", A_ST, pat & 32'hFFFF_0000);
      wrReg(A_ST, 32'hFFFF_FFFF);
      expectReg("R5 ack rest", A_ST, 32'h0);
      // R4: ack while input still active
      srcIn = idle ^ pat;
      tick(4);
      wrReg(A_ST, 32'hFFFF_FFFF);
      expectReg("R4 ack while active", A_ST, md[0] ? 32'h0 : pat);
      srcIn = idle;
      tick(4);
      wrReg(A_ST, 32'hFFFF_FFFF);
      expectReg("R4 ack after release", A_ST, 32'h0);
    end

    // now all sources edge/rising with inputs idle low
    begin
      logic [31:0] frc;
      frc = 32'h0081_4200;
      wrReg(A_FC, frc);
      expectReg("R6 force sets pending", A_ST, frc);
      expectReg("R6 force reads zero", A_FC, 32'h0);
      check("R7 all masked", {31'h0, irqOut}, 32'h1);
      wrReg(A_EN, 32'h0000_0011);
      check("R7 disjoint mask", {31'h0, irqOut}, 32'h1);
      expectReg("R7 masking keeps pending", A_ST, frc);
      wrReg(A_EN, 32'h0000_4000);
      check("R8 low-active level", {31'h0, irqOut}, 32'h0);
      wrReg(A_OP, 32'h1);
      check("R8 high-active level", {31'h0, irqOut}, 32'h1);
      expectReg("R10 outpol readback", A_OP, 32'h1);
      // R9: pulse output, active high
      wrReg(A_EN, 32'h0);
      wrReg(A_OM, 32'h1);
      check("R9 idle high-sense", {31'h0, irqOut}, 32'h0);
      wrReg(A_EN, frc);
      check("R9 pulse high", {31'h0, irqOut}, 32'h1);
      tick(1);
      check("R9 pulse ends", {31'h0, irqOut}, 32'h0);
      // R9: pulse output, active low
      wrReg(A_EN, 32'h0);
      tick(1);
      wrReg(A_OP, 32'h0);
      check("R9 idle low-sense", {31'h0, irqOut}, 32'h1);
      wrReg(A_EN, frc);
      check("R9 pulse low", {31'h0, irqOut}, 32'h0);
      tick(1);
      check("R9 low pulse ends", {31'h0, irqOut}, 32'h1);
      // R10: unmapped offsets
      wrReg(5'h1C, 32'hFFFF_FFFF);
      expectReg("R10 unmapped read", 5'h1C, 32'h0);
      expectReg("R10 unaligned read", 5'h02, 32'h0);
      expectReg("R10 enable untouched", A_EN, frc);
      expectReg("R10 srcmode untouched", A_MD, 32'hFFFF_FFFF);
      expectReg("R10 status untouched", A_ST, frc);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule